// File: doc/BRIEF.md
# DMA Channel and Bus Arbiter

This block decides who owns a shared bus on each slot. The contenders are a set of DMA channels with fixed priority, a memory refresh requester, an external bus-release requester and a data transfer controller that only gets the bus when nothing else wants it. Each DMA transfer is a read slot followed at once by a write slot. A channel can run in single, burst or block mode. In burst or block mode the channel keeps the bus from one read/write pair to the next until its last-transfer flag is seen at the end of a write.

Every bus slot is abstracted. The arbiter shows the slot type on `cyc` and keeps it there until the bus side pulses `slot_done`. An idle bus is re-arbitrated on every clock. When the channel that owns the current DMA pair is marked as targeting on-chip resources, a refresh or bus release that becomes pending can be served alongside the pair. The `ovl` output signals this, and a write-buffer-busy input suppresses it. Each requester is expected to drop its request once it sees its cycle or its overlap indication.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and right after reset, `grant` is 0, `cyc` is idle (0), `req_clr` is 0 and `ovl` is 0.
- R2: At a free point with no refresh or release pending and no channel locked, the lowest-index requesting channel is granted a read (`cyc`=1), and `grant` is its one-hot bit. Index 0 has the highest priority.
- R3: A read that completes is always followed in the very next slot by a write (`cyc`=2) with the same `grant`, whatever other requests are pending. `grant` is nonzero only in read or write slots.
- R4: A channel started in burst (`ch_mode`=1) or block (`ch_mode`=2) mode gets every following read until a write completes while its `ch_last` bit is 1. Other channel requests have no effect on `grant` meanwhile.
- R5: At a free point (bus idle, or any non-read slot completing), a pending refresh gives `cyc`=3. Otherwise a pending release gives `cyc`=4. Only after both does a DMA read start. This also applies inside a locked burst or block, and the locked channel resumes afterwards.
- R6: The transfer controller slot (`cyc`=5) starts only at a free point with no channel request, no refresh, no release and no locked channel.
- R7: A single-mode transfer (`ch_mode`=0) releases the channel after its write, so a higher-priority request pending at that write completion wins the next read.
- R8: `req_clr` pulses for exactly one clock, on the first clock of each read slot, with the bit of the channel being read.
- R9: During a read or write of a channel whose `ch_onchip` bit is 1, with `wbuf_busy` low, a newly pending refresh sets `ovl`=1, or if no refresh is pending a pending release sets `ovl`=2, on the next clock. `ovl` returns to 0 when that request drops or the write completes. When `wbuf_busy` is high, `ovl` stays 0.
- R10: A non-idle slot, together with its `grant`, holds unchanged until `slot_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | NCH | Per-channel transfer request, bit 0 highest priority |
| ch_mode | input | NCH x 2 | Per-channel mode: 0 single, 1 burst, 2 block |
| ch_last | input | NCH | Per-channel last-transfer flag, sampled at write completion |
| ch_onchip | input | NCH | Channel's read and write both target on-chip resources |
| refresh_req | input | 1 | Memory refresh request |
| busrel_req | input | 1 | External bus release request |
| xfer_req | input | 1 | Transfer controller request |
| wbuf_busy | input | 1 | Write buffer in use; blocks overlap |
| slot_done | input | 1 | Current bus slot completes |
| grant | output | NCH | One-hot owner of the current read/write slot |
| cyc | output | 3 | Slot type: 0 idle, 1 read, 2 write, 3 refresh, 4 release, 5 controller |
| req_clr | output | NCH | One-clock request-clear pulse at read start |
| ovl | output | 2 | Overlapped service: 0 none, 1 refresh, 2 release |

## Verification
The assertions assume that `slot_done` is only meaningful while a slot is active and that a requester served by overlap drops its request before the pair's write completes. If it keeps the request, a full refresh or release slot follows, which is also legal. The stimulus changes inputs only between edges. It clears channel requests after their read starts and drops refresh and release requests once served, so every burst, block and overlap scenario ends with the bus idle before the next sweep entry.

// File: rtl/dba_pkg.sv
package dba_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_READ    = 3'd1,
        CYC_WRITE   = 3'd2,
        CYC_REFRESH = 3'd3,
        CYC_RELEASE = 3'd4,
        CYC_CTRL    = 3'd5
    } cyc_e;

    typedef enum logic [1:0] {
        OVL_NONE    = 2'd0,
        OVL_REFRESH = 2'd1,
        OVL_RELEASE = 2'd2
    } ovl_e;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_BURST  = 2'd1;
    localparam logic [1:0] MODE_BLOCK  = 2'd2;
endpackage

// File: rtl/dba_pick.sv
module dba_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign onehot[i]  = req[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | req[i];
    end

    assign any = seen[N];
endmodule

// File: rtl/dba_ovl.sv
module dba_ovl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pair_active,
    input  logic        onchip_sel,
    input  logic        wbuf_busy,
    input  logic        refresh_req,
    input  logic        busrel_req,
    input  logic        wr_done,
    output logic [1:0]  ovl
);
    import dba_pkg::*;

    ovl_e ovl_d, ovl_q;

    always_comb begin
        ovl_d = ovl_q;
        if (ovl_q == OVL_REFRESH && !refresh_req) ovl_d = OVL_NONE;
        if (ovl_q == OVL_RELEASE && !busrel_req)  ovl_d = OVL_NONE;
        if (wr_done) begin
            ovl_d = OVL_NONE;
        end else if (ovl_q == OVL_NONE && pair_active && onchip_sel && !wbuf_busy) begin
            if (refresh_req)     ovl_d = OVL_REFRESH;
            else if (busrel_req) ovl_d = OVL_RELEASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovl_q <= OVL_NONE;
        else        ovl_q <= ovl_d;
    end

    assign ovl = ovl_q;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_req,
    input  logic [NCH-1:0][1:0]  ch_mode,
    input  logic [NCH-1:0]       ch_last,
    input  logic [NCH-1:0]       ch_onchip,
    input  logic                 refresh_req,
    input  logic                 busrel_req,
    input  logic                 xfer_req,
    input  logic                 wbuf_busy,
    input  logic                 slot_done,
    output logic [NCH-1:0]       grant,
    output logic [2:0]           cyc,
    output logic [NCH-1:0]       req_clr,
    output logic [1:0]           ovl
);
    import dba_pkg::*;

    typedef struct packed {
        cyc_e           cyc;
        logic [NCH-1:0] grant;
        logic [NCH-1:0] owner;
        logic [NCH-1:0] clr;
        logic           lock;
    } arb_t;

    arb_t s_d, s_q;

    logic [NCH-1:0] pick_oh;
    logic           pick_any;
    logic [1:0]     pick_mode;
    logic           wr_done;
    logic           last_hit;
    logic           free_pt;
    logic           lock_now;

    dba_pick #(.N(NCH)) u_pick (
        .req    (ch_req),
        .onehot (pick_oh),
        .any    (pick_any)
    );

    always_comb begin
        pick_mode = MODE_SINGLE;
        for (int i = 0; i < NCH; i++) begin
            if (pick_oh[i]) pick_mode = ch_mode[i];
        end
    end

    assign wr_done  = (s_q.cyc == CYC_WRITE) && slot_done;
    assign last_hit = |(s_q.owner & ch_last);
    assign free_pt  = (s_q.cyc == CYC_IDLE) || (slot_done && s_q.cyc != CYC_READ);
    assign lock_now = s_q.lock && !(wr_done && last_hit);

    always_comb begin
        s_d     = s_q;
        s_d.clr = '0;
        if (s_q.cyc == CYC_READ && slot_done) begin
            s_d.cyc = CYC_WRITE;
        end else if (free_pt) begin
            s_d.grant = '0;
            s_d.lock  = lock_now;
            if (refresh_req) begin
                s_d.cyc = CYC_REFRESH;
            end else if (busrel_req) begin
                s_d.cyc = CYC_RELEASE;
            end else if (lock_now) begin
                s_d.cyc   = CYC_READ;
                s_d.grant = s_q.owner;
                s_d.clr   = s_q.owner;
            end else if (pick_any) begin
                s_d.cyc   = CYC_READ;
                s_d.grant = pick_oh;
                s_d.owner = pick_oh;
                s_d.clr   = pick_oh;
                s_d.lock  = (pick_mode == MODE_BURST) || (pick_mode == MODE_BLOCK);
            end else if (xfer_req) begin
                s_d.cyc = CYC_CTRL;
            end else begin
                s_d.cyc = CYC_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dba_ovl u_ovl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_active (s_q.cyc == CYC_READ || s_q.cyc == CYC_WRITE),
        .onchip_sel  (|(s_q.grant & ch_onchip)),
        .wbuf_busy   (wbuf_busy),
        .refresh_req (refresh_req),
        .busrel_req  (busrel_req),
        .wr_done     (wr_done),
        .ovl         (ovl)
    );

    assign grant   = s_q.grant;
    assign cyc     = s_q.cyc;
    assign req_clr = s_q.clr;
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ch_req,
    input logic [NCH-1:0] ch_onchip,
    input logic           refresh_req,
    input logic           busrel_req,
    input logic           wbuf_busy,
    input logic           slot_done,
    input logic [NCH-1:0] grant,
    input logic [2:0]     cyc,
    input logic [NCH-1:0] req_clr,
    input logic [1:0]     ovl
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_GRANT_IN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) == (cyc == 3'd1 || cyc == 3'd2)); // R3

    AST_READ_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3'd1 && slot_done) |=> (cyc == 3'd2 && $stable(grant))); // R3

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3'd2 && $past(cyc) != 3'd2) |-> $past(cyc) == 3'd1); // R3

    AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc == 3'd0 || (slot_done && cyc != 3'd1)) && refresh_req) |=> cyc == 3'd3); // R5

    AST_CTRL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3'd5 && $past(cyc) != 3'd5) |->
        ($past(ch_req) == '0 && !$past(refresh_req) && !$past(busrel_req))); // R6

    AST_CLR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr != '0) |-> (cyc == 3'd1 && req_clr == grant)); // R8

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr != '0) |=> (req_clr == '0)); // R8

    AST_OVL_IN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl != 2'd0) |-> (cyc == 3'd1 || cyc == 3'd2)); // R9

    AST_OVL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovl) == 2'd0 && ovl != 2'd0) |->
        (!$past(wbuf_busy) && $past(grant & ch_onchip) != '0)); // R9

    AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 3'd0 && !slot_done) |=> ($stable(cyc) && $stable(grant))); // R10
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
    localparam int NCH = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH-1:0]      ch_req = '0;
    logic [NCH-1:0][1:0] ch_mode = '0;
    logic [NCH-1:0]      ch_last = '0;
    logic [NCH-1:0]      ch_onchip = '0;
    logic                refresh_req = 1'b0;
    logic                busrel_req = 1'b0;
    logic                xfer_req = 1'b0;
    logic                wbuf_busy = 1'b0;
    logic                slot_done = 1'b0;
    logic [NCH-1:0]      grant;
    logic [2:0]          cyc;
    logic [NCH-1:0]      req_clr;
    logic [1:0]          ovl;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    dma_bus_arbiter #(.NCH(NCH)) u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic done);
        slot_done = done;
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        ch_req = '0; refresh_req = 0; busrel_req = 0; xfer_req = 0;
        ch_last = '0; wbuf_busy = 0;
        for (int k = 0; k < 4; k++) begin
            if (cyc != 3'd0) step(1'b1);
        end
        slot_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset grant", int'(grant), 0);
        chk("R1 reset cyc", int'(cyc), 0);
        chk("R1 reset clr", int'(req_clr), 0);
        chk("R1 reset ovl", int'(ovl), 0);
        rst_n = 1'b1;
        step(1'b0);
        chk("R1 after reset cyc", int'(cyc), 0);

        // Sweep of all request combinations from an idle bus: R2 R5 R6 R8
        for (int p = 0; p < 64; p++) begin
            int ecyc;
            int egnt;
            ch_req = p[2:0]; xfer_req = p[3]; busrel_req = p[4]; refresh_req = p[5];
            egnt = 0;
            if (p[5])           ecyc = 3;
            else if (p[4])      ecyc = 4;
            else if (p[2:0] != 0) begin
                ecyc = 1;
                egnt = p[2:0] & (-p[2:0]);
            end
            else if (p[3])      ecyc = 5;
            else                ecyc = 0;
            step(1'b0);
            chk("R2 sweep cyc", int'(cyc), ecyc);
            chk("R2 sweep grant", int'(grant), egnt);
            chk("R8 sweep clr", int'(req_clr), egnt);
            if (ecyc == 1) begin
                ch_req = '0;
                step(1'b1);
                chk("R3 sweep write", int'(cyc), 2);
                chk("R3 sweep write grant", int'(grant), egnt);
                chk("R8 clr single pulse", int'(req_clr), 0);
            end
            drain();
        end

        // R3: pair is indivisible, then R5 order, R7, R6
        ch_req = 3'b001;
        step(1'b0);
        chk("R3 read ch0", int'(grant), 1);
        ch_req = 3'b110; refresh_req = 1; busrel_req = 1; xfer_req = 1;
        step(1'b1);
        chk("R3 write follows read", int'(cyc), 2);
        chk("R3 write grant", int'(grant), 1);
        step(1'b1);
        chk("R5 refresh after write", int'(cyc), 3);
        step(1'b0);
        chk("R10 refresh holds", int'(cyc), 3);
        refresh_req = 0;
        step(1'b1);
        chk("R5 release next", int'(cyc), 4);
        busrel_req = 0;
        step(1'b1);
        chk("R2 ch1 over ch2", int'(grant), 2);
        ch_req = 3'b100;
        step(1'b1);
        chk("R3 write ch1", int'(cyc), 2);
        step(1'b1);
        chk("R2 ch2 over controller", int'(grant), 4);
        ch_req = '0;
        step(1'b1);
        step(1'b1);
        chk("R6 controller last", int'(cyc), 5);
        drain();

        // R7: single mode re-arbitrates
        ch_req = 3'b010;
        step(1'b0);
        step(1'b1);
        ch_req = 3'b011;
        step(1'b1);
        chk("R7 pre-empt ch0", int'(grant), 1);
        chk("R7 pre-empt cyc", int'(cyc), 1);
        drain();

        // R4: burst lock on ch2
        ch_mode[2] = 2'd1;
        ch_req = 3'b100;
        step(1'b0);
        chk("R4 burst start", int'(grant), 4);
        ch_req = 3'b001;
        step(1'b1);
        step(1'b1);
        chk("R4 burst keeps ch2", int'(grant), 4);
        chk("R8 clr on locked read", int'(req_clr), 4);
        step(1'b1);
        ch_last[2] = 1;
        step(1'b1);
        chk("R4 burst ends", int'(grant), 1);
        ch_mode[2] = 2'd0;
        drain();

        // R4 R5: block on ch1 with insertions
        ch_mode[1] = 2'd2;
        ch_req = 3'b010;
        step(1'b0);
        ch_req = 3'b001;
        step(1'b1);
        refresh_req = 1;
        step(1'b1);
        chk("R5 refresh inside block", int'(cyc), 3);
        chk("R5 no grant in refresh", int'(grant), 0);
        refresh_req = 0; busrel_req = 1;
        step(1'b1);
        chk("R5 release inside block", int'(cyc), 4);
        busrel_req = 0;
        step(1'b1);
        chk("R4 block resumes ch1", int'(grant), 2);
        step(1'b1);
        ch_last[1] = 1;
        step(1'b1);
        chk("R4 block end then ch0", int'(grant), 1);
        ch_mode[1] = 2'd0;
        drain();

        // R9: overlap with on-chip channel
        ch_onchip = 3'b001;
        ch_req = 3'b001;
        step(1'b0);
        ch_req = '0; refresh_req = 1;
        step(1'b0);
        chk("R9 ovl refresh", int'(ovl), 1);
        chk("R9 read continues", int'(cyc), 1);
        step(1'b1);
        chk("R9 ovl held in write", int'(ovl), 1);
        refresh_req = 0;
        step(1'b0);
        chk("R9 ovl drops with req", int'(ovl), 0);
        busrel_req = 1;
        step(1'b0);
        chk("R9 ovl release", int'(ovl), 2);
        step(1'b1);
        chk("R9 ovl cleared at write end", int'(ovl), 0);
        chk("R9 release slot follows", int'(cyc), 4);
        drain();

        // R9: write buffer busy suppresses overlap
        wbuf_busy = 1;
        ch_req = 3'b001;
        step(1'b0);
        ch_req = '0; refresh_req = 1;
        step(1'b0);
        chk("R9 busy no ovl", int'(ovl), 0);
        step(1'b1);
        chk("R9 busy no ovl write", int'(ovl), 0);
        step(1'b1);
        chk("R9 busy refresh slot", int'(cyc), 3);
        drain();

        // R9: off-chip channel does not overlap
        ch_req = 3'b010;
        step(1'b0);
        ch_req = '0; refresh_req = 1;
        step(1'b0);
        chk("R9 offchip no ovl", int'(ovl), 0);
        drain();

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule